// File: doc/BRIEF.md
# Hamming SEC-DED Memory Codec

This block guards words kept in a storage array that can lose bits. It has two
paths that share one numbering of codeword positions. The write path turns a
data word into a codeword: check bits sit at the power-of-two positions, and the
data bits fill the remaining positions. The read path takes a stored codeword
and forms a syndrome in a single XOR pass over all positions. It repairs a
single flipped bit and reports a word that cannot be repaired.

Positions are counted from 1, so a nonzero syndrome is the position of the bad
bit. An optional extra parity bit over the whole word lets the read path tell
single errors from double errors. The read path can drive its results directly,
or through one register stage with a valid strobe. The encoder is always
combinational.

Top module: `hamming_codec`

## Requirements
- R1: The number of check bits K is the smallest value with 2^K - 1 >= DATA_W + K. The codeword is DATA_W + K bits wide, plus one bit when SECDED is 1. This gives 7 bits for 4 data bits, 13 for 8 data bits with SECDED, and 72 for 64 data bits with SECDED.
- R2: Codeword position p (1-based) is held in bit p-1. Check bit i is at position 2^i. Data bit 0 goes in the lowest free position, and the other data bits follow in ascending order. The overall parity bit, when present, is the top bit (index DATA_W + K).
- R3: Check bit i is the even parity of the data positions whose index has bit i set. Data 4'b0110 encodes to 7'b0110011.
- R4: An uncorrupted codeword decodes with syndrome 0, both flags low, and the original data.
- R5: When one bit at position p (1..DATA_W+K) is inverted, the syndrome equals p, single_err is 1, double_err is 0, and the data is corrected.
- R6: When a flipped bit is a check bit, the syndrome points to it, and the data output equals the original data. Flipping position 2 of 0110011 gives syndrome 3'b010.
- R7: With SECDED, a flip of only the overall parity bit gives syndrome 0, single_err 1, double_err 0, and good data.
- R8: With SECDED, any two flipped bits raise double_err with single_err low. The data is then the data bits of the received word, with no bit inverted.
- R9: A nonzero syndrome above DATA_W + K raises double_err, and no bit is inverted.
- R10: With REG_OUT = 1, the results and dec_valid_out appear one clock after dec_valid_in, and reset clears them. With REG_OUT = 0, they follow the inputs in the same cycle. In both modes the flags are low while there is no valid input.
- R11: single_err and double_err are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_data_in | input | DATA_W | Data word to encode |
| enc_code_out | output | DATA_W+K+SECDED | Codeword for enc_data_in |
| dec_valid_in | input | 1 | dec_code_in carries a word to decode |
| dec_code_in | input | DATA_W+K+SECDED | Codeword read back from storage |
| dec_valid_out | output | 1 | Decode results are valid |
| dec_data_out | output | DATA_W | Data, corrected where possible |
| dec_syndrome | output | K | Syndrome (1-based position of a single error) |
| dec_single_err | output | 1 | A single error was corrected |
| dec_double_err | output | 1 | The word is uncorrectable |

## Verification
The assertions assume that dec_code_in is stable around each rising edge and
that reset is applied before the first valid word. The bench therefore drives
every input just after a falling clock edge and holds dec_valid_in low until
reset is released. The classification properties assume that any corruption in
a word is at most a double error, or else a pattern whose syndrome points outside
the word. The bench keeps to single flips, double flips and one such
three-bit pattern, so the expected flags stay well defined.

// File: rtl/hcodec_pkg.sv
package hcodec_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FIXED  = 2'd1,
    ST_UNCORR = 2'd2
  } dec_status_e;

  // smallest K with 2^K - 1 >= m + K
  function automatic int chk_count(input int m);
    int k;
    k = 1;
    while (((1 << k) - 1) < (m + k)) k++;
    return k;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // 1-based codeword position of data bit idx
  function automatic int data_slot(input int idx);
    int p;
    int seen;
    p = 0;
    seen = -1;
    while (seen < idx) begin
      p++;
      if (!is_pow2(p)) seen++;
    end
    return p;
  endfunction

endpackage

// File: rtl/hcodec_enc.sv
module hcodec_enc #(
  parameter int DW     = 8,
  parameter int SECDED = 1
) (
  input  logic [DW-1:0]                                    data_i,
  output logic [DW+hcodec_pkg::chk_count(DW)+SECDED-1:0]   code_o
);
  localparam int K  = hcodec_pkg::chk_count(DW);
  localparam int N  = DW + K;

  // data bits that check bit `bitn` covers
  function automatic logic [DW-1:0] data_cover(input int bitn);
    logic [DW-1:0] m;
    m = '0;
    for (int j = 0; j < DW; j++)
      m[j] = ((hcodec_pkg::data_slot(j) >> bitn) & 1) == 1;
    return m;
  endfunction

  logic [N-1:0] base;

  for (genvar j = 0; j < DW; j++) begin : g_place
    localparam int POS = hcodec_pkg::data_slot(j);
    assign base[POS-1] = data_i[j];
  end

  for (genvar i = 0; i < K; i++) begin : g_chk
    localparam logic [DW-1:0] COVER = data_cover(i);
    assign base[(1 << i) - 1] = ^(data_i & COVER);
  end

  if (SECDED != 0) begin : g_ovl
    assign code_o = {^base, base};
  end else begin : g_plain
    assign code_o = base;
  end

endmodule

// File: rtl/hcodec_syn.sv
module hcodec_syn #(
  parameter int DW     = 8,
  parameter int SECDED = 1
) (
  input  logic [DW+hcodec_pkg::chk_count(DW)+SECDED-1:0] code_i,
  output logic [hcodec_pkg::chk_count(DW)-1:0]           syn_o,
  output logic                                           par_bad_o
);
  localparam int K = hcodec_pkg::chk_count(DW);
  localparam int N = DW + K;

  // positions 1..N whose index has bit `bitn` set
  function automatic logic [N-1:0] pos_mask(input int bitn);
    logic [N-1:0] m;
    m = '0;
    for (int p = 1; p <= N; p++)
      m[p-1] = ((p >> bitn) & 1) == 1;
    return m;
  endfunction

  for (genvar i = 0; i < K; i++) begin : g_syn
    localparam logic [N-1:0] SEL = pos_mask(i);
    assign syn_o[i] = ^(code_i[N-1:0] & SEL);
  end

  if (SECDED != 0) begin : g_par
    assign par_bad_o = ^code_i;
  end else begin : g_nopar
    assign par_bad_o = 1'b0;
  end

endmodule

// File: rtl/hcodec_fix.sv
module hcodec_fix #(
  parameter int DW     = 8,
  parameter int SECDED = 1
) (
  input  logic [DW+hcodec_pkg::chk_count(DW)-1:0] code_i,
  input  logic [hcodec_pkg::chk_count(DW)-1:0]    syn_i,
  input  logic                                    par_bad_i,
  output logic [DW-1:0]                           data_o,
  output logic [DW-1:0]                           data_raw_o,
  output logic                                    single_o,
  output logic                                    double_o,
  output logic                                    beyond_o
);
  import hcodec_pkg::*;
  localparam int K = chk_count(DW);
  localparam int N = DW + K;

  dec_status_e  status;
  logic         nz;
  logic         beyond;
  logic         do_flip;
  logic [N-1:0] flip_mask;
  logic [N-1:0] fixed;

  assign nz     = |syn_i;
  assign beyond = nz && (32'(syn_i) > 32'(N));

  always_comb begin
    if (!nz)                          status = par_bad_i ? ST_FIXED : ST_CLEAN;
    else if (beyond)                  status = ST_UNCORR;
    else if (SECDED != 0 && !par_bad_i) status = ST_UNCORR;
    else                              status = ST_FIXED;
  end

  assign do_flip = (status == ST_FIXED) && nz;

  always_comb begin
    for (int p = 1; p <= N; p++)
      flip_mask[p-1] = do_flip && (syn_i == K'(p));
  end

  assign fixed = code_i ^ flip_mask;

  for (genvar j = 0; j < DW; j++) begin : g_take
    localparam int POS = data_slot(j);
    assign data_o[j]     = fixed[POS-1];
    assign data_raw_o[j] = code_i[POS-1];
  end

  assign single_o = (status == ST_FIXED);
  assign double_o = (status == ST_UNCORR);
  assign beyond_o = beyond;

  always_comb begin
    assert_beyond_noflip_R9: assert (!beyond || flip_mask == '0)
      else $error("R9: bit inverted for out-of-range syndrome");
    assert_one_flip_R5: assert ($countones(flip_mask) <= 1)
      else $error("R5: more than one bit inverted");
  end

endmodule

// File: rtl/hcodec_out.sv
module hcodec_out #(
  parameter int DW      = 8,
  parameter int KW      = 4,
  parameter int REG_OUT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic [KW-1:0] syn_i,
  input  logic          single_i,
  input  logic          double_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic [KW-1:0] syn_o,
  output logic          single_o,
  output logic          double_o
);

  if (REG_OUT != 0) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_o  <= 1'b0;
        data_o   <= '0;
        syn_o    <= '0;
        single_o <= 1'b0;
        double_o <= 1'b0;
      end else begin
        valid_o  <= valid_i;
        data_o   <= data_i;
        syn_o    <= syn_i;
        single_o <= valid_i & single_i;
        double_o <= valid_i & double_i;
      end
    end

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o)
      else $error("R10: valid strobe missing one cycle after input");
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> (!valid_o && !single_o && !double_o))
      else $error("R10: output active without input");
  end else begin : g_comb
    assign valid_o  = valid_i;
    assign data_o   = data_i;
    assign syn_o    = syn_i;
    assign single_o = valid_i & single_i;
    assign double_o = valid_i & double_i;
  end

endmodule

// File: rtl/hamming_codec.sv
module hamming_codec #(
  parameter int DATA_W  = 8,
  parameter int SECDED  = 1,
  parameter int REG_OUT = 1
) (
  input  logic                                                    clk,
  input  logic                                                    rst_n,
  input  logic [DATA_W-1:0]                                       enc_data_in,
  output logic [DATA_W+hcodec_pkg::chk_count(DATA_W)+SECDED-1:0]  enc_code_out,
  input  logic                                                    dec_valid_in,
  input  logic [DATA_W+hcodec_pkg::chk_count(DATA_W)+SECDED-1:0]  dec_code_in,
  output logic                                                    dec_valid_out,
  output logic [DATA_W-1:0]                                       dec_data_out,
  output logic [hcodec_pkg::chk_count(DATA_W)-1:0]                dec_syndrome,
  output logic                                                    dec_single_err,
  output logic                                                    dec_double_err
);
  localparam int K = hcodec_pkg::chk_count(DATA_W);
  localparam int N = DATA_W + K;

  // internal events brought out for checking
  logic [K-1:0]      syn;
  logic              par_bad;
  logic [DATA_W-1:0] fix_data;
  logic [DATA_W-1:0] raw_data;
  logic              fix_single;
  logic              fix_double;
  logic              fix_beyond;

  hcodec_enc #(.DW(DATA_W), .SECDED(SECDED)) u_enc (
    .data_i (enc_data_in),
    .code_o (enc_code_out)
  );

  hcodec_syn #(.DW(DATA_W), .SECDED(SECDED)) u_syn (
    .code_i    (dec_code_in),
    .syn_o     (syn),
    .par_bad_o (par_bad)
  );

  hcodec_fix #(.DW(DATA_W), .SECDED(SECDED)) u_fix (
    .code_i     (dec_code_in[N-1:0]),
    .syn_i      (syn),
    .par_bad_i  (par_bad),
    .data_o     (fix_data),
    .data_raw_o (raw_data),
    .single_o   (fix_single),
    .double_o   (fix_double),
    .beyond_o   (fix_beyond)
  );

  hcodec_out #(.DW(DATA_W), .KW(K), .REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (dec_valid_in),
    .data_i   (fix_data),
    .syn_i    (syn),
    .single_i (fix_single),
    .double_i (fix_double),
    .valid_o  (dec_valid_out),
    .data_o   (dec_data_out),
    .syn_o    (dec_syndrome),
    .single_o (dec_single_err),
    .double_o (dec_double_err)
  );

  assert_clean_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_in && syn == '0 && !par_bad) |->
      (!fix_single && !fix_double && fix_data == raw_data))
    else $error("R4: clean word reported or altered");

  assert_uncorr_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_in && fix_double) |-> (fix_data == raw_data))
    else $error("R8: uncorrectable word was modified");

  assert_beyond_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_in && fix_beyond) |-> fix_double)
    else $error("R9: out-of-range syndrome not flagged");

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_single_err && dec_double_err))
    else $error("R11: both flags high");

endmodule

// File: tb/hamming_codec_test.sv
module hamming_codec_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // 8-bit, SECDED, registered
  logic [7:0]  e8_d;
  logic [12:0] e8_c, d8_c;
  logic        d8_v, d8_vo, d8_s, d8_dd;
  logic [7:0]  d8_data;
  logic [3:0]  d8_syn;
  // 4-bit, plain, combinational
  logic [3:0]  e4_d;
  logic [6:0]  e4_c, d4_c;
  logic        d4_v, d4_vo, d4_s, d4_dd;
  logic [3:0]  d4_data;
  logic [2:0]  d4_syn;
  // 64-bit, SECDED, combinational
  logic [63:0] e64_d;
  logic [71:0] e64_c, d64_c;
  logic        d64_v, d64_vo, d64_s, d64_dd;
  logic [63:0] d64_data;
  logic [6:0]  d64_syn;

  hamming_codec #(.DATA_W(8), .SECDED(1), .REG_OUT(1)) uut (
    .clk(clk), .rst_n(rst_n), .enc_data_in(e8_d), .enc_code_out(e8_c),
    .dec_valid_in(d8_v), .dec_code_in(d8_c), .dec_valid_out(d8_vo),
    .dec_data_out(d8_data), .dec_syndrome(d8_syn),
    .dec_single_err(d8_s), .dec_double_err(d8_dd));

  hamming_codec #(.DATA_W(4), .SECDED(0), .REG_OUT(0)) u4 (
    .clk(clk), .rst_n(rst_n), .enc_data_in(e4_d), .enc_code_out(e4_c),
    .dec_valid_in(d4_v), .dec_code_in(d4_c), .dec_valid_out(d4_vo),
    .dec_data_out(d4_data), .dec_syndrome(d4_syn),
    .dec_single_err(d4_s), .dec_double_err(d4_dd));

  hamming_codec #(.DATA_W(64), .SECDED(1), .REG_OUT(0)) u64 (
    .clk(clk), .rst_n(rst_n), .enc_data_in(e64_d), .enc_code_out(e64_c),
    .dec_valid_in(d64_v), .dec_code_in(d64_c), .dec_valid_out(d64_vo),
    .dec_data_out(d64_data), .dec_syndrome(d64_syn),
    .dec_single_err(d64_s), .dec_double_err(d64_dd));

  // ---------------- reference model ----------------
  function automatic int b_k(input int m);
    int k = 0;
    while ((2 ** k) < (m + k + 1)) k++;
    return k;
  endfunction

  function automatic logic [71:0] b_encode(input int m, input bit sec, input logic [63:0] d);
    int k = b_k(m);
    int n = m + k;
    int di = 0;
    logic [71:0] c = '0;
    bit q = 1'b0;
    for (int p = 1; p <= n; p++)
      if ((p & (p - 1)) != 0) begin c[p-1] = d[di]; di++; end
    for (int i = 0; i < k; i++) begin
      bit x = 1'b0;
      for (int p = 1; p <= n; p++)
        if (((p >> i) & 1) == 1 && p != (1 << i)) x ^= c[p-1];
      c[(1 << i) - 1] = x;
    end
    if (sec) begin
      for (int p = 0; p < n; p++) q ^= c[p];
      c[n] = q;
    end
    return c;
  endfunction

  function automatic logic [63:0] b_extract(input int m, input logic [71:0] c);
    int n = m + b_k(m);
    int di = 0;
    logic [63:0] d = '0;
    for (int p = 1; p <= n; p++)
      if ((p & (p - 1)) != 0) begin d[di] = c[p-1]; di++; end
    return d;
  endfunction

  // syndrome as XOR of the positions of all set bits
  function automatic int b_syn(input int n, input logic [71:0] c);
    int s = 0;
    for (int p = 1; p <= n; p++) if (c[p-1]) s ^= p;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [7:0] data;
    logic [3:0] syn;
    bit         single;
    bit         dbl;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_e;

  always @(negedge clk) begin
    if (rst_n && d8_vo) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected valid", 72'(d8_vo), 72'd0);
      end else begin
        mon_e = sb_q.pop_front();
        check(d8_data == mon_e.data, {mon_e.tag, " data"}, 72'(d8_data), 72'(mon_e.data));
        check(d8_syn == mon_e.syn, {mon_e.tag, " syndrome"}, 72'(d8_syn), 72'(mon_e.syn));
        check(d8_s == mon_e.single && d8_dd == mon_e.dbl, {mon_e.tag, " flags"},
              72'({d8_s, d8_dd}), 72'({mon_e.single, mon_e.dbl}));
        check(!(d8_s && d8_dd), "R11 exclusive flags", 72'({d8_s, d8_dd}), 72'd0);
      end
    end
  end

  task automatic drive8(input logic [7:0] d, input logic [12:0] flips, input int nflip, input string tag);
    logic [71:0] gold;
    logic [71:0] bad;
    exp_t e;
    @(negedge clk);
    e8_d = d;
    #1;
    gold = b_encode(8, 1'b1, 64'(d));
    check(e8_c == gold[12:0], "R1 R2 R3 encode8", 72'(e8_c), gold);
    bad = 72'(gold[12:0] ^ flips);
    d8_c = bad[12:0];
    d8_v = 1'b1;
    e.data   = (nflip <= 1) ? d : b_extract(8, bad) [7:0];
    e.syn    = 4'(b_syn(12, bad));
    e.single = (nflip == 1);
    e.dbl    = (nflip >= 2);
    e.tag    = tag;
    sb_q.push_back(e);
  endtask

  task automatic run4();
    logic [71:0] gold;
    d4_v = 1'b1;
    // worked example: 0110 -> 0110011
    @(negedge clk);
    e4_d = 4'b0110; #1;
    check(e4_c == 7'b0110011, "R3 example encode", 72'(e4_c), 72'h33);
    d4_c = 7'b0110011 ^ 7'b0100000; #1;
    check(d4_syn == 3'b110 && d4_data == 4'b0110 && d4_s, "R5 example pos6",
          72'({d4_syn, d4_data}), 72'({3'b110, 4'b0110}));
    @(negedge clk);
    d4_c = 7'b0110011 ^ 7'b0000010; #1;
    check(d4_syn == 3'b010 && d4_data == 4'b0110, "R6 example pos2",
          72'({d4_syn, d4_data}), 72'({3'b010, 4'b0110}));
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      e4_d = 4'(v); #1;
      gold = b_encode(4, 1'b0, 64'(v));
      check(e4_c == gold[6:0], "R1 R2 R3 encode4", 72'(e4_c), gold);
      d4_c = e4_c; #1;
      check(d4_syn == 0 && !d4_s && !d4_dd && d4_data == 4'(v), "R4 clean4",
            72'({d4_syn, d4_s, d4_dd, d4_data}), 72'(v));
      for (int p = 1; p <= 7; p++) begin
        @(negedge clk);
        d4_c = gold[6:0] ^ (7'd1 << (p - 1)); #1;
        check(d4_syn == 3'(p) && d4_s && !d4_dd && d4_data == 4'(v),
              ((p & (p - 1)) == 0) ? "R6 check-bit flip4" : "R5 data flip4",
              72'({d4_syn, d4_s, d4_dd, d4_data}), 72'({3'(p), 1'b1, 1'b0, 4'(v)}));
      end
    end
    check(d4_vo == d4_v, "R10 comb valid", 72'(d4_vo), 72'(d4_v));
  endtask

  task automatic run64();
    logic [71:0] gold;
    logic [71:0] bad;
    logic [63:0] d;
    int a;
    int b;
    d64_v = 1'b1;
    for (int t = 0; t < 48; t++) begin
      d = {$urandom, $urandom};
      @(negedge clk);
      e64_d = d; #1;
      gold = b_encode(64, 1'b1, d);
      check(e64_c == gold, "R1 R2 R3 encode64", e64_c, gold);
      a = $urandom_range(71, 0);
      bad = gold ^ (72'd1 << a);
      d64_c = bad; #1;
      check(d64_s && !d64_dd && d64_data == d && d64_syn == 7'(b_syn(71, bad)),
            (a == 71) ? "R7 parity flip64" : "R5 flip64",
            72'(d64_data), 72'(d));
      b = $urandom_range(70, 0);
      if (b >= a) b++;
      bad = gold ^ (72'd1 << a) ^ (72'd1 << b);
      @(negedge clk);
      d64_c = bad; #1;
      check(!d64_s && d64_dd && d64_data == b_extract(64, bad), "R8 double64",
            72'({d64_s, d64_dd, d64_data}), 72'({1'b0, 1'b1, b_extract(64, bad)}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    e8_d = '0; d8_c = '0; d8_v = 1'b0;
    e4_d = '0; d4_c = '0; d4_v = 1'b0;
    e64_d = '0; d64_c = '0; d64_v = 1'b0;
    repeat (3) @(negedge clk);
    check(!d8_vo && !d8_s && !d8_dd && d8_data == 0, "R10 reset state",
          72'({d8_vo, d8_s, d8_dd, d8_data}), 72'd0);
    rst_n = 1'b1;

    run4();
    run64();

    for (int v = 0; v < 256; v++) begin
      drive8(8'(v), 13'd0, 0, "R4 clean8");
      for (int b = 0; b < 13; b++)
        drive8(8'(v), 13'd1 << b, 1,
               (b == 12) ? "R7 parity flip8" :
               (((b + 1) & b) == 0) ? "R6 check flip8" : "R5 data flip8");
      for (int b1 = 0; b1 < 13; b1++)
        for (int b2 = b1 + 1; b2 < 13; b2++)
          drive8(8'(v), (13'd1 << b1) | (13'd1 << b2), 2, "R8 double8");
      // positions 1, 2 and 12: syndrome 15 is beyond the 12-position word
      drive8(8'(v), 13'b0100000000011, 3, "R9 out of range");
    end
    @(negedge clk);
    d8_v = 1'b0;
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R10 all results seen", 72'(sb_q.size()), 72'd0);
    check(!d8_vo && !d8_s && !d8_dd, "R10 idle after input stops",
          72'({d8_vo, d8_s, d8_dd}), 72'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule